// File: doc/BRIEF.md
# Quarter-Cycle Fetch and Address Sequencer

This block paces a simple processor's instruction cycle. A clock at four times the instruction rate is divided into four quarters, numbered 0 to 3. Each quarter opens or holds one of two registers. The instruction register is transparent during quarter 0 and closes at the end of that quarter. The program-address register is transparent during quarter 2 and closes at the end of that quarter. This keeps the address presented to program memory steady while the instruction is being fetched.

While the instruction register is in use, the block decodes a bank bit from it and raises one of two I/O select strobes. These strobes tell the I/O devices on the left or right bank to drive the input byte. That byte is captured at the end of quarter 1. The address register opens in quarter 2 and loads one of three next addresses: the sequential successor, a jump target, or the result of a single-bit test on the captured byte that may branch to a signed offset from the current address.

Top module: `qc_fetch_seq`

## Requirements
- R1: The quarter counter steps 0,1,2,3,0,… on every clock. A synchronous reset forces quarter 0, address 0, a cleared instruction register and a cleared captured I/O byte.
- R2: In quarter 0, `ir_o` follows `instr_i`. The value present at the end of quarter 0 is captured and stays on `ir_o`, unchanged, through quarters 1, 2 and 3, whatever `instr_i` does.
- R3: During quarters 0 and 1, `addr_o` keeps the address loaded in the previous instruction cycle.
- R4: During quarter 2, `addr_o` shows the next address. That value is captured at the end of quarter 2 and held through quarter 3.
- R5: An instruction whose opcode (bits 15:13) is neither 111 nor 101 gives a next address of the current address plus 1, modulo 8192 (8191 is followed by 0).
- R6: Opcode 111 is a jump. The next address is bits 12:0 of the instruction.
- R7: Opcode 101 is a bit test. Bits 10:8 select a bit of the I/O byte captured at the end of quarter 1. If that bit is 0, the next address is the current address plus 1. If it is 1, the next address is the current address plus the two's-complement 5-bit offset in bits 4:0, modulo 8192.
- R8: `io_i` is ignored except at the clock edge that ends quarter 1. Values present in quarters 0, 2 and 3 do not affect the branch decision.
- R9: In quarters 0 and 1, an instruction whose opcode is not 111 raises `lb_sel_o` when instruction bit 12 is 0 and `rb_sel_o` when bit 12 is 1. Both strobes are low in quarters 2 and 3 and for jumps, and they are never high together.
- R10: `ir_en_o` is high only in quarter 0 and `ar_en_o` only in quarter 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Quarter-rate clock (four ticks per instruction cycle) |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word from program memory |
| io_i | input | 8 | Input byte from the selected I/O bank |
| quarter_o | output | 2 | Current quarter number |
| addr_o | output | 13 | Program address toward program memory |
| ir_o | output | 16 | Instruction register output (transparent in quarter 0) |
| lb_sel_o | output | 1 | Left-bank I/O select strobe |
| rb_sel_o | output | 1 | Right-bank I/O select strobe |
| ir_en_o | output | 1 | Instruction register open window |
| ar_en_o | output | 1 | Address register open window |

## Verification
Two functions can meet in the same quarter 2. The address register opens, and it must use a branch decision that depends on the I/O byte captured only one edge earlier, while the address from the previous cycle must not leak out early. The bench provokes this with bit tests on every bit index, with the tested bit both set and clear, and with the byte inverted in every quarter except quarter 1. A behavioural model predicts each quarter, and the address seen in quarters 0, 1, 2 and 3 is compared against it. A taken branch from near the top of the address space, and a reset asserted in the middle of quarter 2, test the wrap and the window edges.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

    typedef enum logic [1:0] {
        QTR0 = 2'd0,
        QTR1 = 2'd1,
        QTR2 = 2'd2,
        QTR3 = 2'd3
    } qtr_e;

    // Opcode field and codes
    localparam int unsigned OPC_W     = 3;
    localparam logic [2:0]  OPC_TEST  = 3'b101;
    localparam logic [2:0]  OPC_JUMP  = 3'b111;

    // Field positions inside the instruction word
    localparam int unsigned BANK_BIT  = 12;
    localparam int unsigned IDX_LSB   = 8;
    localparam int unsigned OFF_W     = 5;

endpackage

// File: rtl/qcs_phase_ctr.sv
module qcs_phase_ctr
    import qcs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output qtr_e quarter_o
);

    typedef struct packed {
        qtr_e qtr;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.qtr = qtr_e'(st_q.qtr + 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{qtr: QTR0};
        else     st_q <= st_d;
    end

    assign quarter_o = st_q.qtr;

    // R1
    qtr_step_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.qtr == qtr_e'($past(st_q.qtr) + 2'd1)));

endmodule

// File: rtl/qcs_ir_latch.sv
module qcs_ir_latch
    import qcs_pkg::*;
#(
    parameter int unsigned IW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  qtr_e          quarter_i,
    input  logic [IW-1:0] instr_i,
    output logic [IW-1:0] ir_o,
    output logic          lb_sel_o,
    output logic          rb_sel_o,
    output logic          ir_en_o
);

    typedef struct packed {
        logic [IW-1:0] ir;
    } irst_t;

    irst_t st_d, st_q;

    logic           open_w;
    logic           in_phase;
    logic           uses_io;
    logic [OPC_W-1:0] opc;

    always_comb begin
        open_w   = (quarter_i == QTR0);
        st_d     = st_q;
        if (open_w) st_d.ir = instr_i;
        ir_o     = open_w ? instr_i : st_q.ir;
        opc      = ir_o[IW-1 -: OPC_W];
        uses_io  = (opc != OPC_JUMP);
        in_phase = (quarter_i == QTR0) || (quarter_i == QTR1);
        lb_sel_o = in_phase && uses_io && !ir_o[BANK_BIT];
        rb_sel_o = in_phase && uses_io &&  ir_o[BANK_BIT];
        ir_en_o  = open_w;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i != QTR0) |-> $stable(ir_o));

    // R9
    bank_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({lb_sel_o, rb_sel_o}));

    // R9
    bank_window_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i == QTR2 || quarter_i == QTR3) |-> (!lb_sel_o && !rb_sel_o));

endmodule

// File: rtl/qcs_branch.sv
module qcs_branch
    import qcs_pkg::*;
#(
    parameter int unsigned IW  = 16,
    parameter int unsigned AW  = 13,
    parameter int unsigned IOW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  qtr_e           quarter_i,
    input  logic [IW-1:0]  ir_i,
    input  logic [IOW-1:0] io_i,
    input  logic [AW-1:0]  cur_addr_i,
    output logic [AW-1:0]  next_o
);

    localparam int unsigned IDXW = $clog2(IOW);

    typedef struct packed {
        logic [IOW-1:0] io;
    } brst_t;

    brst_t st_d, st_q;

    logic [OPC_W-1:0] opc;
    logic [IDXW-1:0]  bit_sel;
    logic [OFF_W-1:0] off_raw;
    logic [AW-1:0]    off_ext;
    logic             tested;

    always_comb begin
        st_d = st_q;
        if (quarter_i == QTR1) st_d.io = io_i;

        opc     = ir_i[IW-1 -: OPC_W];
        bit_sel = ir_i[IDX_LSB +: IDXW];
        off_raw = ir_i[OFF_W-1:0];
        off_ext = {{(AW-OFF_W){off_raw[OFF_W-1]}}, off_raw};
        tested  = st_q.io[bit_sel];

        if (opc == OPC_JUMP)
            next_o = ir_i[AW-1:0];
        else if (opc == OPC_TEST && tested)
            next_o = cur_addr_i + off_ext;
        else
            next_o = cur_addr_i + {{(AW-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R8
    io_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i != QTR1) |=> $stable(st_q.io));

endmodule

// File: rtl/qcs_addr_reg.sv
module qcs_addr_reg
    import qcs_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  qtr_e          quarter_i,
    input  logic [AW-1:0] next_i,
    output logic [AW-1:0] cur_addr_o,
    output logic [AW-1:0] addr_o,
    output logic          ar_en_o
);

    typedef struct packed {
        logic [AW-1:0] addr;
    } arst_t;

    arst_t st_d, st_q;

    always_comb begin
        ar_en_o = (quarter_i == QTR2);
        st_d    = st_q;
        if (ar_en_o) st_d.addr = next_i;
        addr_o     = ar_en_o ? next_i : st_q.addr;
        cur_addr_o = st_q.addr;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R3
    addr_early_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i == QTR1) |-> $stable(addr_o));

    // R4
    addr_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (quarter_i == QTR3) |-> $stable(addr_o));

endmodule

// File: rtl/qc_fetch_seq.sv
module qc_fetch_seq
    import qcs_pkg::*;
#(
    parameter int unsigned IW  = 16,
    parameter int unsigned AW  = 13,
    parameter int unsigned IOW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [IW-1:0]  instr_i,
    input  logic [IOW-1:0] io_i,
    output logic [1:0]     quarter_o,
    output logic [AW-1:0]  addr_o,
    output logic [IW-1:0]  ir_o,
    output logic           lb_sel_o,
    output logic           rb_sel_o,
    output logic           ir_en_o,
    output logic           ar_en_o
);

    qtr_e          qtr;
    logic [AW-1:0] next_addr;
    logic [AW-1:0] cur_addr;

    qcs_phase_ctr u_phase (
        .clk       (clk),
        .rst       (rst),
        .quarter_o (qtr)
    );

    qcs_ir_latch #(.IW(IW)) u_ir (
        .clk       (clk),
        .rst       (rst),
        .quarter_i (qtr),
        .instr_i   (instr_i),
        .ir_o      (ir_o),
        .lb_sel_o  (lb_sel_o),
        .rb_sel_o  (rb_sel_o),
        .ir_en_o   (ir_en_o)
    );

    qcs_branch #(.IW(IW), .AW(AW), .IOW(IOW)) u_br (
        .clk        (clk),
        .rst        (rst),
        .quarter_i  (qtr),
        .ir_i       (ir_o),
        .io_i       (io_i),
        .cur_addr_i (cur_addr),
        .next_o     (next_addr)
    );

    qcs_addr_reg #(.AW(AW)) u_ar (
        .clk        (clk),
        .rst        (rst),
        .quarter_i  (qtr),
        .next_i     (next_addr),
        .cur_addr_o (cur_addr),
        .addr_o     (addr_o),
        .ar_en_o    (ar_en_o)
    );

    assign quarter_o = qtr;

    // R10
    win_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ir_en_o, ar_en_o}));

    // R6
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (qtr == QTR3 && $past(ir_o[IW-1 -: OPC_W]) == OPC_JUMP)
            |-> (addr_o == $past(ir_o[AW-1:0])));

endmodule

// File: tb/sim_qc_fetch_seq.sv
module sim_qc_fetch_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] instr_i = '0;
    logic [7:0]  io_i = '0;
    logic [1:0]  quarter_o;
    logic [12:0] addr_o;
    logic [15:0] ir_o;
    logic        lb_sel_o, rb_sel_o, ir_en_o, ar_en_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural model state
    int mq, maddr, mir, mio;

    always #10 clk = ~clk;

    qc_fetch_seq u0 (
        .clk(clk), .rst(rst), .instr_i(instr_i), .io_i(io_i),
        .quarter_o(quarter_o), .addr_o(addr_o), .ir_o(ir_o),
        .lb_sel_o(lb_sel_o), .rb_sel_o(rb_sel_o),
        .ir_en_o(ir_en_o), .ar_en_o(ar_en_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    function automatic int next_of(input int ir, input int addr, input int io);
        int opc, off;
        opc = (ir >> 13) & 7;
        if (opc == 7) return ir & 16'h1FFF;
        if (opc == 5 && (((io >> ((ir >> 8) & 7)) & 1) == 1)) begin
            off = ir & 31;
            if (off >= 16) off -= 32;
            return (addr + off + 8192) % 8192;
        end
        return (addr + 1) % 8192;
    endfunction

    // one quarter: drive, compare with model, advance model
    task automatic step(input logic [15:0] ins, input logic [7:0] io, input bit r);
        int ir_e, nx, opc, lb_e, rb_e, addr_e;
        string at;
        @(negedge clk);
        rst     = r;
        instr_i = (mq < 2) ? ins : (ins ^ 16'hA5C3);   // R2: scrambled late
        io_i    = (mq == 1) ? io : ~io;                // R8: junk off-window
        #1;
        ir_e = (mq == 0) ? int'(instr_i) : mir;
        opc  = (ir_e >> 13) & 7;
        lb_e = (mq < 2 && opc != 7 && ((ir_e >> 12) & 1) == 0) ? 1 : 0;
        rb_e = (mq < 2 && opc != 7 && ((ir_e >> 12) & 1) == 1) ? 1 : 0;
        nx   = next_of(mir, maddr, mio);
        addr_e = (mq == 2) ? nx : maddr;
        if (mq < 2)       at = "R3";
        else if (mq == 3) at = "R4";
        else if (((mir >> 13) & 7) == 7) at = "R4/R6";
        else if (((mir >> 13) & 7) == 5) at = "R4/R7/R8";
        else at = "R4/R5";
        chk("R1 quarter", int'(quarter_o), mq);
        chk("R2 ir", int'(ir_o), ir_e);
        chk(at, int'(addr_o), addr_e);
        chk("R9 lb_sel", int'(lb_sel_o), lb_e);
        chk("R9 rb_sel", int'(rb_sel_o), rb_e);
        chk("R10 ir_en", int'(ir_en_o), (mq == 0) ? 1 : 0);
        chk("R10 ar_en", int'(ar_en_o), (mq == 2) ? 1 : 0);
        if (r) begin
            mq = 0; maddr = 0; mir = 0; mio = 0;
        end else begin
            case (mq)
                0: mir = int'(instr_i);
                1: mio = int'(io_i);
                2: maddr = nx;
                default: ;
            endcase
            mq = (mq + 1) % 4;
        end
    endtask

    task automatic icycle(input logic [15:0] ins, input logic [7:0] io);
        for (int k = 0; k < 4; k++) step(ins, io, 1'b0);
    endtask

    initial begin
        mq = 0; maddr = 0; mir = 0; mio = 0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        // R1: reset state checked by the first steps
        icycle(16'h0000, 8'h00);                  // R5 sequential 0 -> 1
        icycle(16'hFFFE, 8'h00);                  // R6 jump to 1FFE
        icycle(16'h1234, 8'hFF);                  // R5 -> 1FFF, rb bank
        icycle(16'h0042, 8'h00);                  // R5 wrap -> 0
        icycle(16'hA705, 8'h80);                  // R7 taken +5
        icycle(16'hB705, 8'h7F);                  // R7 not taken, rb
        icycle(16'hA310, 8'h08);                  // R7 taken -16 (wraps)
        icycle(16'hFFFE, 8'h00);                  // R6 jump to 1FFE
        icycle(16'hA005, 8'h01);                  // R7 taken: 1FFE+5 -> 3
        for (int i = 0; i < 8; i++) begin         // R7/R8 every bit index
            icycle(16'hA003 | 16'(i << 8), 8'(1 << i));
            icycle(16'hB01E | 16'(i << 8), ~8'(1 << i));
        end
        // R1 mid-cycle reset during quarter 2
        step(16'hE123, 8'h00, 1'b0);
        step(16'hE123, 8'h00, 1'b0);
        step(16'hE123, 8'h00, 1'b1);
        icycle(16'h4000, 8'h00);
        for (int n = 0; n < 400; n++)
            icycle(16'($urandom), 8'($urandom));
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule